// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the status byte of a small 8-bit microcontroller core. Four arithmetic flags (carry, half carry, zero, overflow) follow the ALU: each cycle the instruction decoder names an operation class on `alu_op`, and the block works out the new flag values from the ALU operands and, for logic operations, from the result. Two protected system flags record that the core went into power-down and that the watchdog expired. Ordinary software writes cannot change them. Only the power-up, clear-watchdog, halt and watchdog time-out strobes can.

Software reads and writes the byte over the core's data bus at address 0x0A. A write there loads only the four arithmetic flags. A flag update from the ALU in the same cycle overrides the written value, but only for the flags that the operation affects. The subtract carry is an inverted borrow: it is 1 when no borrow occurred. No data stream crosses this block's edge, so every pin is a plain control or status pin with no valid/ready handshake.

Top module: `status_flag_reg`

## Requirements
- R1: `bus_rdata` shows the status byte while `bus_addr` equals 0x0A. At any other address it is 0x00. Bit layout: C bit 0, AC bit 1, Z bit 2, OV bit 3, PDF bit 4, TO bit 5.
- R2: Bits 7 and 6 of `status_o` and `bus_rdata` are always 0.
- R3: A write at 0x0A with `alu_op`=0 loads C, AC, Z and OV from `bus_wdata[3:0]` at the next edge. PDF and TO keep their value.
- R4: `alu_op` encodes 0 none, 1 add, 2 add with carry, 3 subtract, 4 subtract with carry, 5 logic, 6 rotate left through carry, 7 rotate right through carry. Subtraction computes a + ~b + cin, with cin = 1 for subtract and the current C for the with-carry forms. C takes the carry out of bit 7. For op 6 C takes `alu_a[7]`, for op 7 it takes `alu_a[0]`.
- R5: For ops 1 to 4, AC takes the carry out of bit 3 of the same sum.
- R6: For ops 1 to 4, Z is set when the 8-bit sum is zero. For op 5, Z is set when `alu_res` is zero, and C, AC and OV keep their value.
- R7: For ops 1 to 4, OV is set when the carry into bit 7 differs from the carry out of bit 7.
- R8: PDF is cleared by `pwr_up` or `clr_wdt`. It is set by `halt` when neither of those is active.
- R9: TO is cleared by `pwr_up`. Otherwise it is set by `wdt_timeout`, even in the same cycle as `halt` or `clr_wdt`. Otherwise it is cleared by `clr_wdt` or `halt`.
- R10: When a flag update and a bus write to 0x0A fall in the same cycle, each flag the operation affects takes the update. Every other arithmetic flag takes the written bit.
- R11: While `rst_n` is low, all six flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Data bus address |
| bus_we | input | 1 | Data bus write strobe |
| bus_wdata | input | 8 | Data bus write data |
| bus_rdata | output | 8 | Data bus read data |
| alu_op | input | 3 | Flag-update operation class |
| alu_a | input | 8 | ALU first operand |
| alu_b | input | 8 | ALU second operand |
| alu_res | input | 8 | ALU result, used for logic operations |
| pwr_up | input | 1 | Power-up strobe |
| clr_wdt | input | 1 | Clear-watchdog instruction strobe |
| halt | input | 1 | Halt instruction strobe |
| wdt_timeout | input | 1 | Watchdog time-out strobe |
| status_o | output | 8 | Current status byte |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a bus write at 0x0A and an ALU flag update. The bench issues them together, once with an add that affects all four arithmetic flags and once with a logic operation that affects only Z. It expects the write data to survive exactly in the flags that the operation leaves alone. The second pair is a watchdog time-out together with a halt. The bench expects TO and PDF both set after that single edge.

// File: rtl/status_flag_pkg.sv
package status_flag_pkg;
  localparam int DATA_W = 8;
  localparam int ARITH_N = 4;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ADD  = 3'd1,
    OP_ADC  = 3'd2,
    OP_SUB  = 3'd3,
    OP_SBC  = 3'd4,
    OP_LOGIC = 3'd5,
    OP_RLC  = 3'd6,
    OP_RRC  = 3'd7
  } flag_op_e;

  // Bit positions of the status byte; software decodes these.
  localparam int BIT_C   = 0;
  localparam int BIT_AC  = 1;
  localparam int BIT_Z   = 2;
  localparam int BIT_OV  = 3;
  localparam int BIT_PDF = 4;
  localparam int BIT_TO  = 5;
endpackage

// File: rtl/status_arith_eval.sv
module status_arith_eval
  import status_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [2:0]         op,
  input  logic [W-1:0]       opa,
  input  logic [W-1:0]       opb,
  input  logic [W-1:0]       res,
  input  logic               carry_now,
  output logic [ARITH_N-1:0] upd_mask,
  output logic [ARITH_N-1:0] upd_val
);
  localparam int HALF = W / 2;

  logic           is_arith;
  logic           is_sub;
  logic           cin;
  logic [W-1:0]   opb_eff;
  logic [W:0]     full_sum;
  logic [HALF:0]  low_sum;
  logic [W-1:0]   top_in_sum;
  logic           carry_out;
  logic           carry_msb_in;

  always_comb begin
    is_sub   = (op == OP_SUB) || (op == OP_SBC);
    is_arith = (op == OP_ADD) || (op == OP_ADC) || is_sub;
    unique case (op)
      OP_SUB:          cin = 1'b1;
      OP_ADC, OP_SBC:  cin = carry_now;
      default:         cin = 1'b0;
    endcase
    opb_eff      = is_sub ? ~opb : opb;
    full_sum     = {1'b0, opa} + {1'b0, opb_eff} + {{W{1'b0}}, cin};
    low_sum      = {1'b0, opa[HALF-1:0]} + {1'b0, opb_eff[HALF-1:0]} + {{HALF{1'b0}}, cin};
    top_in_sum   = {1'b0, opa[W-2:0]} + {1'b0, opb_eff[W-2:0]} + {{(W-1){1'b0}}, cin};
    carry_out    = full_sum[W];
    carry_msb_in = top_in_sum[W-1];
  end

  always_comb begin
    upd_mask = '0;
    upd_val  = '0;
    if (is_arith) begin
      upd_mask            = '1;
      upd_val[BIT_C]      = carry_out;
      upd_val[BIT_AC]     = low_sum[HALF];
      upd_val[BIT_Z]      = (full_sum[W-1:0] == '0);
      upd_val[BIT_OV]     = carry_out ^ carry_msb_in;
    end else if (op == OP_LOGIC) begin
      upd_mask[BIT_Z]     = 1'b1;
      upd_val[BIT_Z]      = (res == '0);
    end else if (op == OP_RLC) begin
      upd_mask[BIT_C]     = 1'b1;
      upd_val[BIT_C]      = opa[W-1];
    end else if (op == OP_RRC) begin
      upd_mask[BIT_C]     = 1'b1;
      upd_val[BIT_C]      = opa[0];
    end
  end
endmodule

// File: rtl/status_sys_flags.sv
module status_sys_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_up,
  input  logic clr_wdt,
  input  logic halt,
  input  logic wdt_timeout,
  output logic pdf_q,
  output logic to_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdf_q <= 1'b0;
    end else if (pwr_up || clr_wdt) begin
      pdf_q <= 1'b0;
    end else if (halt) begin
      pdf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q <= 1'b0;
    end else if (pwr_up) begin
      to_q <= 1'b0;
    end else if (wdt_timeout) begin
      to_q <= 1'b1;
    end else if (clr_wdt || halt) begin
      to_q <= 1'b0;
    end
  end
endmodule

// File: rtl/status_bus_port.sv
module status_bus_port
  import status_flag_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] MY_ADDR = 8'h0A
) (
  input  logic [AW-1:0]     addr,
  input  logic              we,
  input  logic [DATA_W-1:0] cur,
  output logic              wr_hit,
  output logic [DATA_W-1:0] rdata
);
  logic hit;
  always_comb begin
    hit    = (addr == MY_ADDR);
    wr_hit = hit && we;
    rdata  = hit ? cur : '0;
  end
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import status_flag_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] REG_ADDR = 8'h0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [2:0]        alu_op,
  input  logic [DATA_W-1:0] alu_a,
  input  logic [DATA_W-1:0] alu_b,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              pwr_up,
  input  logic              clr_wdt,
  input  logic              halt,
  input  logic              wdt_timeout,
  output logic [DATA_W-1:0] status_o
);
  localparam int PAD_W = DATA_W - ARITH_N - 2;

  logic [ARITH_N-1:0] arith_q;
  logic [ARITH_N-1:0] upd_mask;
  logic [ARITH_N-1:0] upd_val;
  logic               wr_hit;
  logic               pdf_q;
  logic               to_q;

  status_arith_eval #(.W(DATA_W)) u_eval (
    .op        (alu_op),
    .opa       (alu_a),
    .opb       (alu_b),
    .res       (alu_res),
    .carry_now (arith_q[BIT_C]),
    .upd_mask  (upd_mask),
    .upd_val   (upd_val)
  );

  status_sys_flags u_sys (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_up      (pwr_up),
    .clr_wdt     (clr_wdt),
    .halt        (halt),
    .wdt_timeout (wdt_timeout),
    .pdf_q       (pdf_q),
    .to_q        (to_q)
  );

  status_bus_port #(.AW(AW), .MY_ADDR(REG_ADDR)) u_port (
    .addr   (bus_addr),
    .we     (bus_we),
    .cur    (status_o),
    .wr_hit (wr_hit),
    .rdata  (bus_rdata)
  );

  for (genvar i = 0; i < ARITH_N; i++) begin : g_arith
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        arith_q[i] <= 1'b0;
      end else if (upd_mask[i]) begin
        arith_q[i] <= upd_val[i];
      end else if (wr_hit) begin
        arith_q[i] <= bus_wdata[i];
      end
    end
  end

  assign status_o = {{PAD_W{1'b0}}, to_q, pdf_q, arith_q};
endmodule

// File: rtl/status_flag_reg_chk.sv
module status_flag_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_addr,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [2:0] alu_op,
  input logic [7:0] alu_res,
  input logic       pwr_up,
  input logic       clr_wdt,
  input logic       halt,
  input logic       wdt_timeout,
  input logic [7:0] status_o
);
  logic quiet_sys;
  assign quiet_sys = !pwr_up && !clr_wdt && !halt && !wdt_timeout;

  p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[7:6] == 2'b00) && (bus_rdata[7:6] == 2'b00));

  p_foreign_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != 8'h0A) |-> (bus_rdata == 8'h00));

  p_write_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h0A && alu_op == 3'd0 && quiet_sys)
      |=> (status_o[3:0] == $past(bus_wdata[3:0])) && $stable(status_o[5:4]));

  p_logic_z_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 3'd5 && !bus_we) |=> (status_o[2] == ($past(alu_res) == 8'h00))
      && (status_o[1:0] == $past(status_o[1:0])) && (status_o[3] == $past(status_o[3])));

  p_halt_pdf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !pwr_up && !clr_wdt) |=> status_o[4]);

  p_clear_pdf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up || clr_wdt) |=> !status_o[4]);

  p_timeout_to_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_timeout && !pwr_up) |=> status_o[5]);

  p_to_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up || ((clr_wdt || halt) && !wdt_timeout)) |=> !status_o[5]);
endmodule

bind status_flag_reg status_flag_reg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .alu_op      (alu_op),
  .alu_res     (alu_res),
  .pwr_up      (pwr_up),
  .clr_wdt     (clr_wdt),
  .halt        (halt),
  .wdt_timeout (wdt_timeout),
  .status_o    (status_o)
);

// File: tb/status_flag_reg_test.sv
`timescale 1ns/1ps
module status_flag_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [2:0] alu_op = 3'd0;
  logic [7:0] alu_a = 8'h00;
  logic [7:0] alu_b = 8'h00;
  logic [7:0] alu_res = 8'h00;
  logic       pwr_up = 1'b0;
  logic       clr_wdt = 1'b0;
  logic       halt = 1'b0;
  logic       wdt_timeout = 1'b0;
  logic [7:0] status_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  status_flag_reg uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alu_op(alu_op),
    .alu_a(alu_a), .alu_b(alu_b), .alu_res(alu_res), .pwr_up(pwr_up),
    .clr_wdt(clr_wdt), .halt(halt), .wdt_timeout(wdt_timeout),
    .status_o(status_o)
  );

  // {prior nibble, op, a, b(/res), expected nibble {OV,Z,AC,C}}
  localparam logic [26:0] VEC [15] = '{
    {4'h0, 3'd1, 8'h01, 8'h01, 4'h0},
    {4'h0, 3'd1, 8'hFF, 8'h01, 4'h7},
    {4'h0, 3'd1, 8'h7F, 8'h01, 4'hA},
    {4'h0, 3'd1, 8'h80, 8'h80, 4'hD},
    {4'h1, 3'd2, 8'h0E, 8'h01, 4'h2},
    {4'h0, 3'd3, 8'h05, 8'h03, 4'h3},
    {4'h0, 3'd3, 8'h03, 8'h05, 4'h0},
    {4'h0, 3'd3, 8'h10, 8'h01, 4'h1},
    {4'h0, 3'd3, 8'h80, 8'h01, 4'h9},
    {4'h0, 3'd3, 8'h42, 8'h42, 4'h7},
    {4'h0, 3'd4, 8'h05, 8'h05, 4'h0},
    {4'hB, 3'd5, 8'h33, 8'h00, 4'hF},
    {4'hF, 3'd5, 8'h00, 8'h5A, 4'hB},
    {4'h0, 3'd6, 8'h80, 8'h00, 4'h1},
    {4'h7, 3'd7, 8'h02, 8'h00, 4'h6}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_we = 1'b0; bus_addr = 8'h00; alu_op = 3'd0;
    pwr_up = 1'b0; clr_wdt = 1'b0; halt = 1'b0; wdt_timeout = 1'b0;
  endtask

  // Inputs set now take effect at the next rising edge; sample at the following falling edge.
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic bus_write(input logic [7:0] d);
    bus_addr = 8'h0A; bus_we = 1'b1; bus_wdata = d;
    tick();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    bus_addr = 8'h0A;
    #1 check("R11 reset state", status_o, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: R4 carry, R5 half carry, R6 zero, R7 overflow
    for (int i = 0; i < 15; i++) begin
      bus_write({4'h0, VEC[i][26:23]});
      alu_op = VEC[i][22:20]; alu_a = VEC[i][19:12];
      alu_b = VEC[i][11:4];   alu_res = VEC[i][11:4];
      tick();
      check($sformatf("R4/R5/R6/R7 vector %0d", i), status_o, {4'h0, VEC[i][3:0]});
    end

    // R3 / R2: write of all ones loads only arithmetic flags
    bus_write(8'hFF);
    check("R3 write masks system flags", status_o, 8'h0F);
    bus_addr = 8'h0A; #1;
    check("R1 read at register address", bus_rdata, 8'h0F);
    check("R2 upper bits read zero", {bus_rdata[7:6], 6'h0}, 8'h00);
    bus_addr = 8'h0B; #1;
    check("R1 other address reads zero", bus_rdata, 8'h00);

    // R8 halt sets PDF, clears TO
    halt = 1'b1; tick();
    check("R8 halt sets PDF", status_o, 8'h1F);
    bus_write(8'h00);
    check("R3 write keeps PDF", status_o, 8'h10);

    // R9 time-out together with halt
    wdt_timeout = 1'b1; halt = 1'b1; tick();
    check("R9 timeout beats halt", status_o, 8'h30);
    bus_write(8'h00);
    check("R3 write keeps TO", status_o, 8'h30);
    halt = 1'b1; tick();
    check("R9 halt clears TO", status_o, 8'h10);
    wdt_timeout = 1'b1; tick();
    clr_wdt = 1'b1; tick();
    check("R8 R9 clear-watchdog clears both", status_o, 8'h00);
    wdt_timeout = 1'b1; clr_wdt = 1'b1; halt = 1'b1; tick();
    check("R8 R9 clear beats halt, timeout beats clear", status_o, 8'h20);
    halt = 1'b1; wdt_timeout = 1'b1; pwr_up = 1'b1; tick();
    check("R8 R9 power-up clears", status_o, 8'h00);

    // R10 collisions
    bus_addr = 8'h0A; bus_we = 1'b1; bus_wdata = 8'h08;
    alu_op = 3'd1; alu_a = 8'hFF; alu_b = 8'h01; tick();
    check("R10 add overrides write", status_o, 8'h07);
    bus_addr = 8'h0A; bus_we = 1'b1; bus_wdata = 8'h0D;
    alu_op = 3'd5; alu_res = 8'h5A; tick();
    check("R10 logic overrides Z only", status_o, 8'h09);
    bus_addr = 8'h0A; bus_we = 1'b1; bus_wdata = 8'h00;
    alu_op = 3'd6; alu_a = 8'h80; tick();
    check("R10 rotate overrides C only", status_o, 8'h01);
    bus_addr = 8'h3A; bus_we = 1'b1; bus_wdata = 8'h0E; tick();
    check("R1 write elsewhere ignored", status_o, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule